// File: doc/BRIEF.md
# Start-Vector Gated Bit Recovery

This block sits behind a receive data slicer. It takes the sliced serial stream, recovers bit timing by oversampling, and searches the mid-bit samples for the 16-bit start pattern 0xE2E2. Until the pattern is found, the data output follows the raw slicer input and the strobe output stays low. When the last bit of the pattern has been sampled, the block locks. From the next bit onward, the data output carries the recovered bits, each one presented with a strobe pulse.

Lock persists while the search enable is held high. Taking the enable low clears the lock and stops the search. Raising it again starts a fresh search. A rate select input picks the slow rate (high) or the fast rate (low). The fast rate is four times the slow rate by default, matching a 4.8 kbit/s and 19.2 kbit/s pair.

Top module: `vs_gated_rx`

## Requirements
- R1: `rx_strobe_o` stays low until the mid-bit samples, taken first bit as the most significant bit, form exactly 0xE2E2. A near-miss pattern such as 0xE2E3 produces no strobe.
- R2: While the block is not locked, `rx_data_o` equals `rx_raw_i` combinationally, including during reset.
- R3: Once the block is locked, `rx_data_o` carries the last recovered bit and no longer follows `rx_raw_i`.
- R4: Every bit after the pattern produces exactly one strobe pulse, with its value delivered in order. The pattern bits themselves produce no pulse.
- R5: The recovered bit changes in the cycle the strobe rises and holds until the strobe falls.
- R6: After lock, strobe pulses continue once per bit period while the enable stays high, even when the input does not change.
- R7: While `search_en_i` is low, the block does not lock, the strobe stays low and data passes through. A pattern sent during that time is ignored.
- R8: Driving `search_en_i` low and then high re-arms the search, so a later pattern locks the block again.
- R9: The bit period is OSR*DIV_FAST*RATE_RATIO clocks (128) with `rate_slow_i` high and OSR*DIV_FAST clocks (32) with it low. Consecutive strobe rises during data are exactly one bit period apart.
- R10: Each strobe pulse is high for exactly half a bit period: 64 clocks at the slow rate and 16 at the fast rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_raw_i | input | 1 | Sliced serial receive data |
| search_en_i | input | 1 | Enables the search; a low-then-high sequence re-arms it |
| rate_slow_i | input | 1 | 1 selects the slow rate, 0 the fast rate |
| rx_data_o | output | 1 | Raw data before lock, recovered bits after lock |
| rx_strobe_o | output | 1 | Recovered bit strobe, low until lock |

## Verification
Each test sends an idle run, a near-miss pattern (0xE2E3), the true pattern followed by a 16-bit payload at each rate, a constant tail, and the true pattern again while the enable is low. The near-miss shows that the correlator needs a full 16-bit match. The two payloads (0xA53C slow, 0x96C3 fast) show bit order, pulse count, pulse width and spacing at both rates. The constant tail separates free-running bit timing from timing that only follows input edges. The pattern sent with the enable low, followed by a lock after re-enable, shows that the re-arm works and that the search is blocked while the enable is low.

// File: rtl/vs_gated_rx_pkg.sv
package vs_gated_rx_pkg;
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] START_VEC = 16'hE2E2;
endpackage

// File: rtl/vs_bit_timer.sv
module vs_bit_timer #(
  parameter int OSR         = 16,
  parameter int DIV_FAST    = 2,
  parameter int RATE_RATIO  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_slow_i,
  input  logic rx_i,
  output logic rx_s_o,
  output logic mid_o
);
  localparam int DIV_SLOW = DIV_FAST * RATE_RATIO;
  localparam int DW       = $clog2(DIV_SLOW + 1);
  localparam int PW       = $clog2(OSR);
  localparam logic [DW-1:0] LIM_SLOW = DW'(DIV_SLOW - 1);
  localparam logic [DW-1:0] LIM_FAST = DW'(DIV_FAST - 1);
  localparam logic [PW-1:0] PH_MID   = PW'(OSR/2 - 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(OSR - 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [DW-1:0]        div_q;
  logic [PW-1:0]        ph_q;
  logic                 rx_edge, tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], rx_i};

  assign rx_s_o  = sync_q[SYNC_STAGES-1];
  assign rx_edge = sync_q[SYNC_STAGES-1] ^ sync_q[SYNC_STAGES];
  assign tick    = (div_q == (rate_slow_i ? LIM_SLOW : LIM_FAST));

  // resync the oversampling phase on every input transition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ph_q  <= '0;
    end else if (rx_edge) begin
      div_q <= '0;
      ph_q  <= '0;
    end else if (tick) begin
      div_q <= '0;
      ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign mid_o = tick && !rx_edge && (ph_q == PH_MID);

  a_r9_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ph_q) < OSR);
  a_r9_mid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_o |=> !mid_o);
endmodule

// File: rtl/vs_correlator.sv
module vs_correlator
  import vs_gated_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mid_i,
  input  logic bit_i,
  output logic lock_o
);
  logic [VEC_W-1:0] sh_q;
  logic [VEC_W-1:0] sh_nx;
  logic             lock_q;

  assign sh_nx = {sh_q[VEC_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      lock_q <= 1'b0;
    end else if (!en_i) begin
      sh_q   <= '0;
      lock_q <= 1'b0;
    end else if (mid_i && !lock_q) begin
      sh_q <= sh_nx;
      if (sh_nx == START_VEC) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;

  a_r6_lock_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && en_i) |=> lock_q);
  a_r7_disabled_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lock_q);
  a_r1_lock_on_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(mid_i));
endmodule

// File: rtl/vs_strobe_gen.sv
module vs_strobe_gen #(
  parameter int HW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          lock_i,
  input  logic          mid_i,
  input  logic          bit_i,
  input  logic [HW-1:0] half_m1_i,
  output logic          strobe_o,
  output logic          bit_o
);
  logic          strobe_q, bit_q;
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      bit_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (!en_i || !lock_i) begin
      strobe_q <= 1'b0;
      cnt_q    <= '0;
    end else if (mid_i) begin
      strobe_q <= 1'b1;
      bit_q    <= bit_i;
      cnt_q    <= '0;
    end else if (strobe_q) begin
      if (cnt_q == half_m1_i) strobe_q <= 1'b0;
      else                    cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign strobe_o = strobe_q;
  assign bit_o    = bit_q;

  a_r2_strobe_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !strobe_q);
  a_r5_bit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && !mid_i) |=> $stable(bit_q));
  a_r10_width_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && en_i && lock_i && !mid_i && cnt_q < half_m1_i) |=> strobe_q);
endmodule

// File: rtl/vs_gated_rx.sv
module vs_gated_rx
  import vs_gated_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DIV_FAST    = 2,
  parameter int RATE_RATIO  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_raw_i,
  input  logic search_en_i,
  input  logic rate_slow_i,
  output logic rx_data_o,
  output logic rx_strobe_o
);
  localparam int HALF_SLOW = (OSR / 2) * DIV_FAST * RATE_RATIO;
  localparam int HALF_FAST = (OSR / 2) * DIV_FAST;
  localparam int HW        = $clog2(HALF_SLOW + 1);

  logic [SYNC_STAGES-1:0] en_q;
  logic                   en_s, rx_s, mid, lock, rec_bit;
  logic [HW-1:0]          half_m1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= '0;
    else         en_q <= {en_q[SYNC_STAGES-2:0], search_en_i};

  assign en_s    = en_q[SYNC_STAGES-1];
  assign half_m1 = rate_slow_i ? HW'(HALF_SLOW - 1) : HW'(HALF_FAST - 1);

  vs_bit_timer #(
    .OSR(OSR), .DIV_FAST(DIV_FAST), .RATE_RATIO(RATE_RATIO), .SYNC_STAGES(SYNC_STAGES)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_slow_i(rate_slow_i),
    .rx_i(rx_raw_i), .rx_s_o(rx_s), .mid_o(mid)
  );

  vs_correlator u_corr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_s),
    .mid_i(mid), .bit_i(rx_s), .lock_o(lock)
  );

  vs_strobe_gen #(.HW(HW)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_s), .lock_i(lock),
    .mid_i(mid), .bit_i(rx_s), .half_m1_i(half_m1),
    .strobe_o(rx_strobe_o), .bit_o(rec_bit)
  );

  assign rx_data_o = lock ? rec_bit : rx_raw_i;
endmodule

// File: tb/sim_vs_gated_rx.sv
`timescale 1ns/1ps
module sim_vs_gated_rx;
  localparam int OSR = 16, DIV_FAST = 2, RATE_RATIO = 4;

  logic clk = 1'b0, rst_n = 1'b0, rx_raw = 1'b0, en = 1'b0, rate_slow = 1'b1;
  logic rx_data, rx_strobe;
  int   n_chk = 0, n_fail = 0, rises = 0, extra = 0, cyc = 0;
  bit   done = 1'b0;
  logic exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vs_gated_rx #(.OSR(OSR), .DIV_FAST(DIV_FAST), .RATE_RATIO(RATE_RATIO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_raw_i(rx_raw), .search_en_i(en),
    .rate_slow_i(rate_slow), .rx_data_o(rx_data), .rx_strobe_o(rx_strobe)
  );

  function automatic int bit_clks();
    return rate_slow ? OSR * DIV_FAST * RATE_RATIO : OSR * DIV_FAST;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // driver: MSB first, one bit period per bit, payload bits queued for the monitor
  task automatic send(input logic [31:0] v, input int n, input bit push);
    for (int i = n - 1; i >= 0; i--) begin
      rx_raw = v[i];
      if (push) exp_q.push_back(v[i]);
      repeat (bit_clks()) @(negedge clk);
    end
  endtask

  // monitor / scoreboard
  initial begin
    int  r_cyc, prev_r, f_cyc;
    bit  prev_ok;
    logic d, e;
    prev_ok = 1'b0; prev_r = 0;
    forever begin
      @(posedge rx_strobe);
      rises++;
      @(negedge clk);
      r_cyc = cyc;
      d = rx_data;
      if (exp_q.size() > 0) begin
        if (prev_ok) chk((r_cyc - prev_r) == bit_clks(), "R9 strobe spacing", r_cyc - prev_r, bit_clks());
        @(negedge rx_strobe);
        @(negedge clk);
        f_cyc = cyc;
        e = exp_q.pop_front();
        chk(d == e, "R4 recovered bit at rise", int'(d), int'(e));
        chk(rx_data == e, "R5 bit stable at fall", int'(rx_data), int'(e));
        chk((f_cyc - r_cyc) == bit_clks() / 2, "R10 strobe width", f_cyc - r_cyc, bit_clks() / 2);
        prev_ok = 1'b1;
      end else begin
        extra++;
        prev_ok = 1'b0;
      end
      prev_r = r_cyc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(rx_strobe == 1'b0, "R1 strobe low in reset", int'(rx_strobe), 0);
    rx_raw = 1'b1; #1;
    chk(rx_data == 1'b1, "R2 passthrough in reset", int'(rx_data), 1);
    rx_raw = 1'b0; #1;
    chk(rx_data == 1'b0, "R2 passthrough in reset", int'(rx_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (10) @(negedge clk);

    // near-miss pattern at slow rate
    send(32'h0, 4, 0);
    base = rises;
    send(32'hE2E3, 16, 0);
    send(32'h0, 8, 0);
    chk(rises == base, "R1 no strobe on near miss", rises - base, 0);
    rx_raw = 1'b1; #1;
    chk(rx_data == 1'b1, "R2 passthrough unlocked", int'(rx_data), 1);
    rx_raw = 1'b0; #1;
    chk(rx_data == 1'b0, "R2 passthrough unlocked", int'(rx_data), 0);
    repeat (2 * bit_clks()) @(negedge clk);

    // true pattern and payload at slow rate
    base = rises;
    send(32'hE2E2, 16, 0);
    chk(rises == base, "R4 no pulse for pattern bits", rises - base, 0);
    send(32'hA53C, 16, 1);
    repeat (20) @(negedge clk);
    chk(rises - base == 16, "R4 one pulse per payload bit", rises - base, 16);
    rx_raw = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_data == 1'b0, "R3 recovered data not raw", int'(rx_data), 0);
    repeat (4 * bit_clks()) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all slow payload delivered", exp_q.size(), 0);
    chk(extra >= 3, "R6 strobe continues on constant input", extra, 3);
    chk(rx_data == 1'b1, "R3 recovered constant level", int'(rx_data), 1);

    // enable low: search blocked
    en = 1'b0;
    repeat (10) @(negedge clk);
    base = rises;
    send(32'h0, 4, 0);
    send(32'hE2E2, 16, 0);
    send(32'h0, 4, 0);
    chk(rises == base, "R7 no strobe while disabled", rises - base, 0);
    rx_raw = 1'b1; #1;
    chk(rx_data == 1'b1, "R7 passthrough while disabled", int'(rx_data), 1);
    rx_raw = 1'b0; #1;
    chk(rx_data == 1'b0, "R7 passthrough while disabled", int'(rx_data), 0);

    // re-arm at fast rate
    rate_slow = 1'b0;
    en = 1'b1;
    repeat (10) @(negedge clk);
    send(32'h0, 4, 0);
    base = rises;
    send(32'hE2E2, 16, 0);
    send(32'h96C3, 16, 1);
    repeat (10) @(negedge clk);
    chk(rises - base == 16, "R8 relock after re-arm", rises - base, 16);
    repeat (bit_clks()) @(negedge clk);
    chk(exp_q.size() == 0, "R9 fast payload delivered", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule